// File: doc/BRIEF.md
# Vectored 64-Source Interrupt Controller

This block gathers 64 interrupt request lines and turns their changes into a stream of (vector, level) events for a downstream interrupt controller. For every source it keeps a request bit, an in-service bit, a mask bit and an edge-select bit. It also holds an 8-bit vector that is sent with each of that source's events. Software reaches the state through a 32-bit register port. Every 64-bit register is reached as two 32-bit halves. The vector table is reached as one byte per source.

A single write to the mask or clear register, or one clock in which several inputs change, can produce events for many sources. Those events go into a pending bitmap. They leave one per valid/ready handshake, lowest source number first. The register port stalls while the bitmap holds any bit. Input changes that arrive during that time are not lost as long as they are still present: the block samples the inputs again once the batch is empty.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the mask, edge, forward-enable, request (IRR) and in-service (ISR) registers and every vector byte read 0. `evt_valid` is 0 and `req_ready` is 1.
- R2: Each 64-bit register is reached as two 32-bit halves. Address bit 2 set selects bits 63:32 and clear selects bits 31:0. A write to one half leaves the other half unchanged.
- R3: When input `src_i[k]` rises, IRR[k] is set. If mask[k] is 0, ISR[k] is also set and an event is sent with the vector of source k and `evt_level`=1.
- R4: When `src_i[k]` falls with edge[k]=1, nothing changes. With edge[k]=0, IRR[k] clears. If ISR[k] was set, ISR[k] also clears and an event is sent with `evt_level`=0. ISR is never set while IRR is clear.
- R5: A write to the clear register selects the sources whose IRR bit is 1, whose edge bit is 1 and whose data bit is 1 in the written half. Their IRR bits clear, and those with ISR set clear ISR and send a level-0 event. Level sources and idle sources are unaffected.
- R6: A mask bit that goes from 1 to 0 sets ISR and sends a level-1 event when IRR is set. A mask bit that goes from 0 to 1 sends a level-0 event only when ISR is set and IRR is clear. A source masked while still requesting keeps ISR set. Unchanged mask bits produce no event.
- R7: Events caused by one write or one input sample leave one per `evt_valid`&`evt_ready` handshake, in ascending source order. An event is held stable while `evt_ready` is 0. `req_ready` stays 0 until the last event of the batch has left.
- R8: Vector byte k sits at byte offset VEC+k. A write there stores the byte, a read returns it in bits 7:0, and events for source k carry it.
- R9: Route bytes always read 1. The two auto-control registers and the polarity register always read 0, whatever was written to them.
- R10: The identification word reads `ID_LOW` in its low half. Its high half has the version in bits 7:0 and 31 in bits 31:16.
- R11: `req_size` encodes 1, 2, 4 or 8 bytes as 0, 1, 2 or 3. An access whose address is not a multiple of its size is rejected with `rsp_err`=1 and changes no state. So are accesses to unmapped offsets, writes to the read-only ID, IRR and ISR views, and reads of the clear register.
- R12: The edge and forward-enable registers store and return what was written. Edge bit 1 selects edge behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 64 | Source request levels, synchronous to clk |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset within the block |
| req_size | input | 2 | Access size code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Register port can accept an access |
| rsp_valid | output | 1 | Response, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access rejected |
| evt_valid | output | 1 | Event available |
| evt_ready | input | 1 | Downstream accepts the event |
| evt_vec | output | 8 | Vector of the event's source |
| evt_level | output | 1 | 1 = assert, 0 = deassert |

## Verification
The bench goes after these cases:
- An edge source falling. A design that treated it as level would clear IRR and send a spurious deassert.
- A clear write that names a pending level source. A design that skipped the edge term would drop a live request.
- Masking a source that is still requesting. A design acting on mask levels instead of transitions would clear ISR or send an event.
- Several sources completing in the same write or sample. A design with a wrong priority would emit them out of ascending order, and one with a faulty handshake would drop or repeat an event or let the port accept a write mid-batch.
- A half write. A design with a faulty merge would corrupt the untouched half.
- A misaligned write. A design with a missing alignment check would change the mask.

// File: rtl/virq_pkg.sv
package virq_pkg;

  localparam int NSRC  = 64;
  localparam int HALFW = 32;
  localparam int VECW  = 8;
  localparam int SRCIW = $clog2(NSRC);

  typedef enum logic [3:0] {
    RG_NONE, RG_ID, RG_MASK, RG_FWD, RG_EDGE, RG_CLR,
    RG_AUTO, RG_POL, RG_ROUTE, RG_VEC, RG_IRR, RG_ISR
  } region_e;

  // pick one 32-bit half of a 64-bit register
  function automatic logic [HALFW-1:0] f_half(input logic [NSRC-1:0] v, input logic hi);
    return hi ? v[NSRC-1:HALFW] : v[HALFW-1:0];
  endfunction

  // replace one half, keep the other
  function automatic logic [NSRC-1:0] f_merge(input logic [NSRC-1:0] v, input logic hi,
                                              input logic [HALFW-1:0] d);
    return hi ? {d, v[HALFW-1:0]} : {v[NSRC-1:HALFW], d};
  endfunction

  // place a 32-bit per-source bit set at its 64-bit position
  function automatic logic [NSRC-1:0] f_spread(input logic hi, input logic [HALFW-1:0] d);
    return hi ? {d, {HALFW{1'b0}}} : {{HALFW{1'b0}}, d};
  endfunction

  // low address bits must be zero for the access size
  function automatic logic f_misaligned(input logic [2:0] a, input logic [1:0] sz);
    case (sz)
      2'd0:    return 1'b0;
      2'd1:    return a[0];
      2'd2:    return |a[1:0];
      default: return |a[2:0];
    endcase
  endfunction

endpackage

// File: rtl/virq_lowpick.sv
module virq_lowpick #(
  parameter int N  = 64,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;

  AST_PICK_IS_SET:  assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> req_i[idx_o]);                                          // R7
  AST_PICK_LOWEST:  assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((req_i & ~({N{1'b1}} << idx_o)) == '0));               // R7

endmodule

// File: rtl/virq_vectab.sv
module virq_vectab #(
  parameter int N  = 64,
  parameter int W  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] ra,
  output logic [W-1:0]  rda,
  input  logic [IW-1:0] rb,
  output logic [W-1:0]  rdb
);

  logic [W-1:0] ent [N];

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n)                        ent[g] <= '0;
      else if (we && waddr == IW'(g))    ent[g] <= wdata;
    end
  end

  assign rda = ent[ra];
  assign rdb = ent[rb];

endmodule

// File: rtl/virq_regdec.sv
module virq_regdec
  import virq_pkg::*;
#(
  parameter int AW        = 10,
  parameter int OFF_ID    = 'h000,
  parameter int OFF_MASK  = 'h020,
  parameter int OFF_FWD   = 'h040,
  parameter int OFF_EDGE  = 'h060,
  parameter int OFF_CLR   = 'h080,
  parameter int OFF_AUTO0 = 'h0C0,
  parameter int OFF_AUTO1 = 'h0E0,
  parameter int OFF_ROUTE = 'h100,
  parameter int OFF_VEC   = 'h200,
  parameter int OFF_IRR   = 'h380,
  parameter int OFF_ISR   = 'h3A0,
  parameter int OFF_POL   = 'h3E0
) (
  input  logic [AW-1:0]    addr,
  input  logic [1:0]       size,
  input  logic             write,
  output region_e          region,
  output logic             hi,
  output logic [SRCIW-1:0] bidx,
  output logic             err
);

  localparam int REGB = 8;

  function automatic logic in_rng(input logic [AW-1:0] a, input int base, input int span);
    return (int'(a) >= base) && (int'(a) < base + span);
  endfunction

  always_comb begin
    region = RG_NONE;
    bidx   = '0;
    hi     = addr[2];
    if      (in_rng(addr, OFF_ID,    REGB)) region = RG_ID;
    else if (in_rng(addr, OFF_MASK,  REGB)) region = RG_MASK;
    else if (in_rng(addr, OFF_FWD,   REGB)) region = RG_FWD;
    else if (in_rng(addr, OFF_EDGE,  REGB)) region = RG_EDGE;
    else if (in_rng(addr, OFF_CLR,   REGB)) region = RG_CLR;
    else if (in_rng(addr, OFF_AUTO0, REGB)) region = RG_AUTO;
    else if (in_rng(addr, OFF_AUTO1, REGB)) region = RG_AUTO;
    else if (in_rng(addr, OFF_POL,   REGB)) region = RG_POL;
    else if (in_rng(addr, OFF_IRR,   REGB)) region = RG_IRR;
    else if (in_rng(addr, OFF_ISR,   REGB)) region = RG_ISR;
    else if (in_rng(addr, OFF_ROUTE, NSRC)) begin
      region = RG_ROUTE;
      bidx   = SRCIW'(int'(addr) - OFF_ROUTE);
    end
    else if (in_rng(addr, OFF_VEC, NSRC)) begin
      region = RG_VEC;
      bidx   = SRCIW'(int'(addr) - OFF_VEC);
    end
    err = f_misaligned(addr[2:0], size)
        || (region == RG_NONE)
        || (write  && (region == RG_ID || region == RG_IRR || region == RG_ISR))
        || (!write && region == RG_CLR);
  end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import virq_pkg::*;
#(
  parameter int          AW        = 10,
  parameter int          OFF_ID    = 'h000,
  parameter int          OFF_MASK  = 'h020,
  parameter int          OFF_FWD   = 'h040,
  parameter int          OFF_EDGE  = 'h060,
  parameter int          OFF_CLR   = 'h080,
  parameter int          OFF_AUTO0 = 'h0C0,
  parameter int          OFF_AUTO1 = 'h0E0,
  parameter int          OFF_ROUTE = 'h100,
  parameter int          OFF_VEC   = 'h200,
  parameter int          OFF_IRR   = 'h380,
  parameter int          OFF_ISR   = 'h3A0,
  parameter int          OFF_POL   = 'h3E0,
  parameter logic [31:0] ID_LOW    = 32'h5A00_0001,
  parameter logic [7:0]  ID_VER    = 8'h01,
  parameter logic [15:0] ID_TOP    = 16'd31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [63:0]      src_i,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_size,
  input  logic [31:0]      req_wdata,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_err,
  output logic             evt_valid,
  input  logic             evt_ready,
  output logic [7:0]       evt_vec,
  output logic             evt_level
);

  // ---------------- state ----------------
  logic [NSRC-1:0] irr_q, isr_q, mask_q, fwd_q, edge_q, seen_q, pend_q, lvl_q;
  logic [NSRC-1:0] irr_d, isr_d, mask_d, fwd_d, edge_d, seen_d, pend_d, lvl_d;

  // ---------------- named internal events ----------------
  logic             idle, acc, wr_ok;
  logic [NSRC-1:0]  hit_up, hit_dn;          // assert / deassert rule firings
  logic [NSRC-1:0]  rise, fall;              // input transitions in a sample cycle
  logic             sample;                  // inputs examined this cycle
  logic             evt_fire;
  logic [NSRC-1:0]  clr_sel;

  // ---------------- decode ----------------
  region_e          dec_region;
  logic             dec_hi, dec_err;
  logic [SRCIW-1:0] dec_bidx;

  virq_regdec #(
    .AW(AW), .OFF_ID(OFF_ID), .OFF_MASK(OFF_MASK), .OFF_FWD(OFF_FWD),
    .OFF_EDGE(OFF_EDGE), .OFF_CLR(OFF_CLR), .OFF_AUTO0(OFF_AUTO0),
    .OFF_AUTO1(OFF_AUTO1), .OFF_ROUTE(OFF_ROUTE), .OFF_VEC(OFF_VEC),
    .OFF_IRR(OFF_IRR), .OFF_ISR(OFF_ISR), .OFF_POL(OFF_POL)
  ) u_dec (
    .addr(req_addr), .size(req_size), .write(req_write),
    .region(dec_region), .hi(dec_hi), .bidx(dec_bidx), .err(dec_err)
  );

  // ---------------- event picker ----------------
  logic             pick_any;
  logic [SRCIW-1:0] pick_idx;

  virq_lowpick #(.N(NSRC)) u_pick (
    .clk(clk), .rst_n(rst_n), .req_i(pend_q), .any_o(pick_any), .idx_o(pick_idx)
  );

  // ---------------- vector table ----------------
  logic            vec_we;
  logic [VECW-1:0] vec_rda, vec_rdb;

  virq_vectab #(.N(NSRC), .W(VECW)) u_vec (
    .clk(clk), .rst_n(rst_n),
    .we(vec_we), .waddr(dec_bidx), .wdata(req_wdata[VECW-1:0]),
    .ra(dec_bidx), .rda(vec_rda), .rb(pick_idx), .rdb(vec_rdb)
  );

  assign idle      = !pick_any;
  assign req_ready = idle;
  assign acc       = req_valid && idle;
  assign wr_ok     = acc && req_write && !dec_err;
  assign vec_we    = wr_ok && dec_region == RG_VEC;
  assign sample    = idle && !acc;
  assign rise      = sample ? (src_i & ~seen_q) : '0;
  assign fall      = sample ? (~src_i & seen_q) : '0;

  assign evt_valid = pick_any;
  assign evt_vec   = vec_rdb;
  assign evt_level = lvl_q[pick_idx];
  assign evt_fire  = evt_valid && evt_ready;

  // ---------------- next state ----------------
  logic [HALFW-1:0] old_h;

  always_comb begin
    irr_d   = irr_q;
    mask_d  = mask_q;
    fwd_d   = fwd_q;
    edge_d  = edge_q;
    seen_d  = seen_q;
    hit_up  = '0;
    hit_dn  = '0;
    clr_sel = '0;
    old_h   = f_half(mask_q, dec_hi);

    if (wr_ok) begin
      case (dec_region)
        RG_MASK: begin
          mask_d = f_merge(mask_q, dec_hi, req_wdata);
          hit_up = f_spread(dec_hi, old_h & ~req_wdata) & irr_q & ~mask_d;
          hit_dn = f_spread(dec_hi, ~old_h & req_wdata) & isr_q & ~irr_q;
        end
        RG_FWD:  fwd_d  = f_merge(fwd_q, dec_hi, req_wdata);
        RG_EDGE: edge_d = f_merge(edge_q, dec_hi, req_wdata);
        RG_CLR: begin
          clr_sel = f_spread(dec_hi, req_wdata) & irr_q & edge_q;
          irr_d   = irr_q & ~clr_sel;
          hit_dn  = clr_sel & isr_q & ~irr_d;
        end
        default: ;
      endcase
    end else if (sample) begin
      seen_d = src_i;
      irr_d  = (irr_q | rise) & ~(fall & ~edge_q);
      hit_up = rise & irr_d & ~mask_q;
      hit_dn = fall & ~edge_q & isr_q & ~irr_d;
    end

    isr_d = (isr_q | hit_up) & ~hit_dn;

    if (idle) begin
      pend_d = hit_up | hit_dn;
      lvl_d  = hit_up;
    end else begin
      pend_d = evt_fire ? (pend_q & ~(NSRC'(1) << pick_idx)) : pend_q;
      lvl_d  = lvl_q;
    end
  end

  // ---------------- read data ----------------
  logic [31:0] rd_data;

  always_comb begin
    case (dec_region)
      RG_ID:    rd_data = dec_hi ? {ID_TOP, 8'h00, ID_VER} : ID_LOW;
      RG_MASK:  rd_data = f_half(mask_q, dec_hi);
      RG_FWD:   rd_data = f_half(fwd_q, dec_hi);
      RG_EDGE:  rd_data = f_half(edge_q, dec_hi);
      RG_IRR:   rd_data = f_half(irr_q, dec_hi);
      RG_ISR:   rd_data = f_half(isr_q, dec_hi);
      RG_ROUTE: rd_data = 32'd1;
      RG_VEC:   rd_data = {{(32-VECW){1'b0}}, vec_rda};
      default:  rd_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr_q  <= '0; isr_q  <= '0; mask_q <= '0; fwd_q <= '0;
      edge_q <= '0; seen_q <= '0; pend_q <= '0; lvl_q <= '0;
      rsp_valid <= 1'b0; rsp_err <= 1'b0; rsp_rdata <= '0;
    end else begin
      irr_q  <= irr_d;  isr_q  <= isr_d;  mask_q <= mask_d; fwd_q <= fwd_d;
      edge_q <= edge_d; seen_q <= seen_d; pend_q <= pend_d; lvl_q <= lvl_d;
      rsp_valid <= acc;
      rsp_err   <= acc && dec_err;
      rsp_rdata <= (acc && !req_write && !dec_err) ? rd_data : '0;
    end
  end

  // ---------------- assertions ----------------
  AST_EVT_HOLD:    assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_vec) && $stable(evt_level))); // R7
  AST_BUSY_STALL:  assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |-> !req_ready);                                                      // R7
  AST_DRAIN_ONE:   assert property (@(posedge clk) disable iff (!rst_n)
    evt_fire |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));            // R7
  AST_ISR_SUBSET:  assert property (@(posedge clk) disable iff (!rst_n)
    (isr_q & ~irr_q) == '0);                                                        // R4
  AST_EDGE_KEEP:   assert property (@(posedge clk) disable iff (!rst_n)
    (sample && (fall & edge_q & irr_q) != '0) |=> ((irr_q & $past(fall & edge_q & irr_q)) == $past(fall & edge_q & irr_q))); // R4
  AST_RSP_NEXT:    assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> rsp_valid);                                                             // R11
  AST_ERR_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && dec_err) |=> ($stable(mask_q) && $stable(edge_q) && $stable(irr_q))); // R11

endmodule

// File: tb/test_vec_irq_ctrl.sv
`timescale 1ns/1ps
module test_vec_irq_ctrl;

  localparam int A_ID = 'h000, A_MASK = 'h020, A_FWD = 'h040, A_EDGE = 'h060,
                 A_CLR = 'h080, A_AUTO0 = 'h0C0, A_AUTO1 = 'h0E0, A_ROUTE = 'h100,
                 A_VEC = 'h200, A_IRR = 'h380, A_ISR = 'h3A0, A_POL = 'h3E0;

  logic        clk = 0, rst_n = 0;
  logic [63:0] src_i = '0;
  logic        req_valid = 0, req_write = 0;
  logic [9:0]  req_addr = '0;
  logic [1:0]  req_size = 2'd2;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err, evt_valid, evt_level;
  logic [31:0] rsp_rdata;
  logic        evt_ready = 0;
  logic [7:0]  evt_vec;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_size(req_size), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_vec(evt_vec), .evt_level(evt_level)
  );

  function automatic logic [7:0] vexp(input int k);
    return 8'((k * 37 + 5) & 255);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input int addr, input logic [1:0] sz, input logic [31:0] d,
                        output logic [31:0] rdat, output logic err);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = 10'(addr); req_size = sz; req_wdata = d;
    @(negedge clk);
    req_valid = 0;
    rdat = rsp_rdata; err = rsp_err;
  endtask

  task automatic wr32(input int addr, input logic [31:0] d);
    logic [31:0] r; logic e;
    access(1, addr, 2'd2, d, r, e);
  endtask

  task automatic rd_chk(input int addr, input logic [1:0] sz, input logic [31:0] exp, input string tag);
    logic [31:0] r; logic e;
    access(0, addr, sz, 0, r, e);
    check(!e && r == exp, tag, {e, r}, {1'b0, exp});
  endtask

  task automatic get_evt(input logic [7:0] v, input logic l, input string tag);
    int n = 0;
    @(negedge clk);
    while (!evt_valid && n < 20) begin @(negedge clk); n++; end
    check(evt_valid && evt_vec == v && evt_level == l, tag, {evt_valid, evt_level, evt_vec}, {1'b1, l, v});
    evt_ready = 1;
    @(negedge clk);
    evt_ready = 0;
  endtask

  task automatic no_evt(input string tag);
    repeat (4) @(negedge clk);
    check(!evt_valid, tag, evt_valid, 0);
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk);
    src_i = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] r; logic e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(!evt_valid && req_ready, "R1 idle flags", {evt_valid, req_ready}, 2'b01);
    rd_chk(A_MASK, 2, 0, "R1 mask lo");
    rd_chk(A_MASK + 4, 2, 0, "R1 mask hi");
    rd_chk(A_EDGE, 2, 0, "R1 edge");
    rd_chk(A_IRR, 2, 0, "R1 irr");
    rd_chk(A_ISR + 4, 2, 0, "R1 isr hi");
    rd_chk(A_VEC + 9, 0, 0, "R1 vector");

    // R8 vector table sweep
    for (int k = 0; k < 64; k++) access(1, A_VEC + k, 2'd0, {24'h0, vexp(k)}, r, e);
    for (int k = 0; k < 64; k++) rd_chk(A_VEC + k, 0, {24'h0, vexp(k)}, "R8 vector byte");

    // R10 identification
    rd_chk(A_ID, 2, 32'h5A00_0001, "R10 id low");
    rd_chk(A_ID + 4, 2, 32'h001F_0001, "R10 id high");

    // R2 halves
    wr32(A_MASK + 4, 32'hA5A5_0F0F);
    wr32(A_MASK, 32'h1234_5678);
    rd_chk(A_MASK, 2, 32'h1234_5678, "R2 lo");
    rd_chk(A_MASK + 4, 2, 32'hA5A5_0F0F, "R2 hi");
    wr32(A_MASK, 0);
    rd_chk(A_MASK + 4, 2, 32'hA5A5_0F0F, "R2 hi untouched");
    wr32(A_MASK + 4, 0);
    no_evt("R6 unmask without request");

    // R12 edge/forward registers
    wr32(A_EDGE, 32'h0000_00F0);
    wr32(A_EDGE + 4, 32'h8000_0000);
    wr32(A_FWD, 32'hDEAD_BEEF);
    rd_chk(A_EDGE, 2, 32'h0000_00F0, "R12 edge lo");
    rd_chk(A_EDGE + 4, 2, 32'h8000_0000, "R12 edge hi");
    rd_chk(A_FWD, 2, 32'hDEAD_BEEF, "R12 fwd lo");

    // R3/R4 level source 2
    set_src(64'h4);
    get_evt(vexp(2), 1, "R3 level assert");
    rd_chk(A_IRR, 2, 32'h4, "R3 irr set");
    rd_chk(A_ISR, 2, 32'h4, "R3 isr set");
    set_src(64'h0);
    get_evt(vexp(2), 0, "R4 level deassert");
    rd_chk(A_ISR, 2, 0, "R4 isr clear");

    // R4/R5 edge source 5
    set_src(64'h20);
    get_evt(vexp(5), 1, "R3 edge assert");
    set_src(64'h0);
    no_evt("R4 edge fall ignored");
    rd_chk(A_IRR, 2, 32'h20, "R4 edge irr kept");
    set_src(64'h8);
    get_evt(vexp(3), 1, "R3 level src3");
    wr32(A_CLR, 32'h0000_002C);
    get_evt(vexp(5), 0, "R5 clear deassert");
    no_evt("R5 single event");
    rd_chk(A_IRR, 2, 32'h8, "R5 level kept, edge cleared");
    set_src(64'h0);
    get_evt(vexp(3), 0, "R4 src3 deassert");

    // R6/R7 batches
    wr32(A_MASK, 32'hFFFF_FFFF);
    wr32(A_MASK + 4, 32'hFFFF_FFFF);
    set_src(64'h0004_0100_0002_0402);   // sources 1,10,17,40,50
    no_evt("R6 masked rise silent");
    rd_chk(A_IRR, 2, 32'h0002_0402, "R3 masked irr lo");
    rd_chk(A_ISR, 2, 0, "R6 masked isr lo");
    wr32(A_MASK, 32'h0000_0400);
    @(negedge clk);
    check(!req_ready && evt_valid, "R7 port stalls", {req_ready, evt_valid}, 2'b01);
    repeat (3) @(negedge clk);
    check(evt_valid && evt_vec == vexp(1), "R7 held", evt_vec, vexp(1));
    get_evt(vexp(1), 1, "R7 first lowest");
    get_evt(vexp(17), 1, "R7 second");
    no_evt("R6 src10 stays masked");
    check(req_ready, "R7 port free", req_ready, 1);
    wr32(A_MASK + 4, 0);
    get_evt(vexp(40), 1, "R7 hi first");
    get_evt(vexp(50), 1, "R7 hi second");
    wr32(A_MASK, 32'hFFFF_FFFF);
    no_evt("R6 mask while requesting silent");
    rd_chk(A_ISR, 2, 32'h0002_0002, "R6 isr kept");
    set_src(64'h0);
    get_evt(vexp(1), 0, "R7 fall batch 1");
    get_evt(vexp(17), 0, "R7 fall batch 17");
    get_evt(vexp(40), 0, "R7 fall batch 40");
    get_evt(vexp(50), 0, "R7 fall batch 50");
    no_evt("R4 src10 no isr no event");
    wr32(A_MASK, 0);
    no_evt("R6 unmask idle");

    // R9 fixed registers
    access(1, A_ROUTE + 3, 2'd0, 32'h55, r, e);
    rd_chk(A_ROUTE + 3, 0, 32'd1, "R9 route");
    wr32(A_AUTO0, 32'hFFFF);
    wr32(A_AUTO1 + 4, 32'h1234);
    wr32(A_POL, 32'hFFFF_FFFF);
    rd_chk(A_AUTO0, 2, 0, "R9 auto0");
    rd_chk(A_AUTO1 + 4, 2, 0, "R9 auto1");
    rd_chk(A_POL, 2, 0, "R9 polarity");

    // R11 errors
    access(0, A_MASK + 1, 2'd2, 0, r, e);
    check(e, "R11 misaligned read", e, 1);
    access(1, A_MASK + 2, 2'd2, 32'hFFFF_FFFF, r, e);
    check(e, "R11 misaligned write", e, 1);
    rd_chk(A_MASK, 2, 0, "R11 mask unchanged");
    access(0, 'h3F0, 2'd2, 0, r, e);
    check(e, "R11 unmapped", e, 1);
    access(0, A_CLR, 2'd2, 0, r, e);
    check(e, "R11 clear read", e, 1);
    access(1, A_IRR, 2'd2, 32'h1, r, e);
    check(e, "R11 irr write", e, 1);
    rd_chk(A_IRR, 2, 0, "R11 irr unchanged");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule